// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits in a root port and gathers the error messages that arrive from below. Each message carries a severity class and a 16-bit requester identifier. The block keeps a set of sticky "received" flags in a root status register, together with first/multiple tracking and a flag for a fatal error that arrived before any other uncorrectable one. It also keeps the identifiers of the first correctable and the first uncorrectable sender.

A three-bit root command register enables an interrupt for each severity class. The interrupt condition is formed from the received flags and these enables. In level mode the condition drives an interrupt line directly. In message mode the block emits a one-cycle notify pulse together with a 5-bit vector number, and only when the condition changes from false to true.

Software reaches the block through a small register write port and a read port. The status flags are write-one-to-clear. The vector number is supplied from outside and can be read back in the status register.

Top module: `rerr_collector`

## Requirements
- R1: When `rst` is high at a clock edge, the command register, all status flags, both source registers, `irq_level` and `notify` become zero.
- R2: A message with `msg_sev`=0 (correctable) sets status bit 0 (correctable received). If bit 0 was already set, it also sets bit 1 (multiple correctable). If bit 0 was clear, it loads the correctable source register, which reads on `rd_data[15:0]` when `rd_sel`=2. A `msg_sev` of 3 changes nothing.
- R3: A message with `msg_sev`=1 (non-fatal) sets bit 5, and one with `msg_sev`=2 (fatal) sets bit 6. Either one sets bit 2 (uncorrectable received). If bit 2 was already set, it also sets bit 3 (multiple uncorrectable). If bit 2 was clear, it loads the uncorrectable source register, which reads on `rd_data[31:16]` when `rd_sel`=2.
- R4: A fatal message sets bit 4 (first error was fatal) only when bit 2 was clear before that message.
- R5: The interrupt condition is (bit0 AND cmd[0]) OR (bit5 AND cmd[1]) OR (bit6 AND cmd[2]). In level mode (`msi_mode`=0), `irq_level` equals this condition one cycle after any message, command write or status clear.
- R6: In message mode (`msi_mode`=1), `notify` pulses for exactly one cycle when the condition goes from false to true. The change may come from a message or from a command write. `irq_level` stays 0 in this mode.
- R7: `vec_in` is registered into status bits 31:27 every cycle. With each notify pulse, `notify_vec` carries the `vec_in` value from the cycle that produced the pulse.
- R8: A status write (`wr_sel`=1) clears each of bits 6:0 where `wr_data` holds a one, and leaves all other bits unchanged. If a message arrives in the same cycle, the clear is applied first and the message is then judged against the cleared flags.
- R9: A command write (`wr_sel`=0) loads `wr_data[2:0]`. `rd_sel`=0 returns the command in bits 2:0, `rd_sel`=1 returns the status register, and `rd_sel`=2 returns the two source registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_mode | input | 1 | 1 selects notify pulses, 0 selects the level interrupt |
| vec_in | input | 5 | Vector number supplied from outside |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal |
| msg_src | input | 16 | Requester identifier of the message |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 command register, 1 status register (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 command, 1 status, 2 sources |
| rd_data | output | 32 | Read data (combinational from registers) |
| irq_level | output | 1 | Level interrupt |
| notify | output | 1 | One-cycle notification pulse |
| notify_vec | output | 5 | Vector number sent with the pulse |

## Verification
The sweep covers every ordered pair of severities, under all eight command-enable patterns and in both interrupt modes. Sending the same class twice shows whether the multiple-receipt flags are set and whether the first source is kept. Mixed pairs, such as non-fatal followed by fatal and fatal followed by non-fatal, tell the first-fatal rule apart from a plain fatal flag. Enable patterns that exclude the arriving class separate the condition from raw receipt, and a later command write checks the rising-edge notify. A status clear applied in the same cycle as a correctable message checks the ordering of clear and update.

// File: rtl/rerr_pkg.sv
package rerr_pkg;
  localparam int NUM_CLASS = 3;
  localparam int FLAG_W    = 7;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_NONE     = 2'd3
  } sev_e;

  // bit 0 is cor_rcv, bit 6 is fatal_rcv
  typedef struct packed {
    logic fatal_rcv;
    logic nonfatal_rcv;
    logic first_fatal;
    logic multi_uncor;
    logic uncor_rcv;
    logic multi_cor;
    logic cor_rcv;
  } rstat_t;
endpackage

// File: rtl/rerr_status_upd.sv
module rerr_status_upd
  import rerr_pkg::*;
(
  input  rstat_t              cur,
  input  logic [FLAG_W-1:0]   clr,
  input  logic                msg_valid,
  input  logic [1:0]          msg_sev,
  output rstat_t              nxt,
  output logic                cor_cap,
  output logic                unc_cap
);
  rstat_t cleared;
  logic   is_unc;

  always_comb begin
    cleared = rstat_t'(cur & ~clr);
    nxt     = cleared;
    cor_cap = 1'b0;
    unc_cap = 1'b0;
    is_unc  = 1'b0;
    if (msg_valid) begin
      case (sev_e'(msg_sev))
        SEV_COR: begin
          if (cleared.cor_rcv) nxt.multi_cor = 1'b1;
          else                 cor_cap = 1'b1;
          nxt.cor_rcv = 1'b1;
        end
        SEV_NONFATAL: begin
          nxt.nonfatal_rcv = 1'b1;
          is_unc = 1'b1;
        end
        SEV_FATAL: begin
          if (!cleared.uncor_rcv) nxt.first_fatal = 1'b1;
          nxt.fatal_rcv = 1'b1;
          is_unc = 1'b1;
        end
        default: ;
      endcase
      if (is_unc) begin
        if (cleared.uncor_rcv) nxt.multi_uncor = 1'b1;
        else                   unc_cap = 1'b1;
        nxt.uncor_rcv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rerr_irq_gen.sv
module rerr_irq_gen #(
  parameter int NCLS  = 3,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msi_mode,
  input  logic [NCLS-1:0]  rcv_nxt,
  input  logic [NCLS-1:0]  en_nxt,
  input  logic [VEC_W-1:0] vec_nxt,
  output logic             irq_level,
  output logic             notify,
  output logic [VEC_W-1:0] notify_vec
);
  logic [NCLS-1:0] gated;
  logic            cond_nxt;
  logic            cond_q;

  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    assign gated[i] = rcv_nxt[i] & en_nxt[i];
  end
  assign cond_nxt = |gated;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q     <= 1'b0;
      irq_level  <= 1'b0;
      notify     <= 1'b0;
      notify_vec <= '0;
    end else begin
      cond_q    <= cond_nxt;
      irq_level <= !msi_mode && cond_nxt;
      notify    <= msi_mode && cond_nxt && !cond_q;
      if (msi_mode && cond_nxt && !cond_q) notify_vec <= vec_nxt;
    end
  end

  // R6
  notify_single_chk: assert property (@(posedge clk) disable iff (rst)
    notify |=> !notify);
endmodule

// File: rtl/rerr_collector.sv
module rerr_collector
  import rerr_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msi_mode,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic             irq_level,
  output logic             notify,
  output logic [VEC_W-1:0] notify_vec
);
  localparam int PAD_W = 32 - VEC_W - FLAG_W;

  logic [NUM_CLASS-1:0] cmd_q, cmd_nxt;
  rstat_t               stat_q, stat_nxt;
  logic [SRC_W-1:0]     csrc_q, usrc_q;
  logic [VEC_W-1:0]     vec_q;
  logic [FLAG_W-1:0]    clr;
  logic                 cor_cap, unc_cap;
  logic [NUM_CLASS-1:0] rcv_nxt;

  assign cmd_nxt = (wr_en && !wr_sel) ? wr_data[NUM_CLASS-1:0] : cmd_q;
  assign clr     = (wr_en && wr_sel) ? wr_data[FLAG_W-1:0] : '0;

  rerr_status_upd u_upd (
    .cur       (stat_q),
    .clr       (clr),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .nxt       (stat_nxt),
    .cor_cap   (cor_cap),
    .unc_cap   (unc_cap)
  );

  assign rcv_nxt = {stat_nxt.fatal_rcv, stat_nxt.nonfatal_rcv, stat_nxt.cor_rcv};

  rerr_irq_gen #(.NCLS(NUM_CLASS), .VEC_W(VEC_W)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .msi_mode   (msi_mode),
    .rcv_nxt    (rcv_nxt),
    .en_nxt     (cmd_nxt),
    .vec_nxt    (vec_in),
    .irq_level  (irq_level),
    .notify     (notify),
    .notify_vec (notify_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= '0;
      csrc_q <= '0;
      usrc_q <= '0;
      vec_q  <= '0;
    end else begin
      cmd_q  <= cmd_nxt;
      stat_q <= stat_nxt;
      vec_q  <= vec_in;
      if (cor_cap) csrc_q <= msg_src;
      if (unc_cap) usrc_q <= msg_src;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {{(32-NUM_CLASS){1'b0}}, cmd_q};
      2'd1:    rd_data = {vec_q, {PAD_W{1'b0}}, stat_q};
      2'd2:    rd_data = {usrc_q, csrc_q};
      default: rd_data = '0;
    endcase
  end

  // R5
  level_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_level == (!$past(msi_mode) &&
      ((stat_q.cor_rcv && cmd_q[0]) || (stat_q.nonfatal_rcv && cmd_q[1]) ||
       (stat_q.fatal_rcv && cmd_q[2]))));
  // R2
  multi_cor_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q.multi_cor) |-> $past(stat_q.cor_rcv));
  // R4
  first_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q.first_fatal) |-> (stat_q.fatal_rcv && stat_q.uncor_rcv));
  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !msg_valid |=> ($stable(csrc_q) && $stable(usrc_q)));
endmodule

// File: tb/rerr_collector_tb_top.sv
module rerr_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        msi_mode;
  logic [4:0]  vec_in;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        irq_level, notify;
  logic [4:0]  notify_vec;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [6:0]  m_st;
  logic [2:0]  m_cmd;
  logic [15:0] m_cs, m_us;
  logic        m_cond;

  always #5 clk = ~clk;

  rerr_collector dut_i (
    .clk(clk), .rst(rst), .msi_mode(msi_mode), .vec_in(vec_in),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_level(irq_level),
    .notify(notify), .notify_vec(notify_vec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cond_of();
    return (m_st[0] & m_cmd[0]) | (m_st[5] & m_cmd[1]) | (m_st[6] & m_cmd[2]);
  endfunction

  // drive at negedge, one clock, update model, check at next negedge
  task automatic op(logic v, logic [1:0] sev, logic [15:0] src,
                    logic we, logic ws, logic [31:0] wd, string tag);
    logic old_c, new_c;
    msg_valid = v; msg_sev = sev; msg_src = src;
    wr_en = we; wr_sel = ws; wr_data = wd;
    old_c = m_cond;
    if (we && !ws) m_cmd = wd[2:0];
    if (we && ws)  m_st = m_st & ~wd[6:0];
    if (v && sev == 2'd0) begin
      if (m_st[0]) m_st[1] = 1'b1; else m_cs = src;
      m_st[0] = 1'b1;
    end else if (v && (sev == 2'd1 || sev == 2'd2)) begin
      if (sev == 2'd1) m_st[5] = 1'b1;
      else begin
        if (!m_st[2]) m_st[4] = 1'b1;
        m_st[6] = 1'b1;
      end
      if (m_st[2]) m_st[3] = 1'b1; else m_us = src;
      m_st[2] = 1'b1;
    end
    new_c = cond_of();
    m_cond = new_c;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0; wr_en = 1'b0;
    chk({tag, " R5 irq_level"}, {31'b0, irq_level}, {31'b0, !msi_mode && new_c});
    chk({tag, " R6 notify"}, {31'b0, notify}, {31'b0, msi_mode && new_c && !old_c});
    if (msi_mode && new_c && !old_c)
      chk({tag, " R7 notify_vec"}, {27'b0, notify_vec}, {27'b0, vec_in});
    rd_sel = 2'd1; #1;
    chk({tag, " status"}, rd_data, {vec_in, 20'b0, m_st});
    rd_sel = 2'd0; #1;
    chk({tag, " R9 cmd"}, rd_data, {29'b0, m_cmd});
    rd_sel = 2'd2; #1;
    chk({tag, " sources"}, rd_data, {m_us, m_cs});
  endtask

  task automatic do_reset(logic mode, logic [4:0] v);
    msi_mode = mode; vec_in = v;
    rst = 1'b1; msg_valid = 1'b0; wr_en = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_st = '0; m_cmd = '0; m_cs = '0; m_us = '0; m_cond = 1'b0;
  endtask

  function automatic string sev_tag(int s);
    return (s == 0) ? "R2" : (s == 1) ? "R3" : "R4";
  endfunction

  initial begin
    rd_sel = 2'd0; msg_sev = 2'd0; msg_src = '0; wr_sel = 1'b0; wr_data = '0;
    do_reset(1'b0, 5'd3);
    // R1 reset state
    chk("R1 irq_level", {31'b0, irq_level}, 32'd0);
    chk("R1 notify", {31'b0, notify}, 32'd0);
    rd_sel = 2'd0; #1; chk("R1 cmd", rd_data, 32'd0);
    rd_sel = 2'd2; #1; chk("R1 sources", rd_data, 32'd0);

    for (int mode = 0; mode < 2; mode++)
      for (int en = 0; en < 8; en++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++) begin
            do_reset(mode[0], 5'(en * 3 + a + 1));
            op(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 32'(en), "R9 cmd write");
            op(1'b1, 2'(a), 16'(16'h1000 + a), 1'b0, 1'b0, 32'h0, sev_tag(a));
            op(1'b1, 2'(b), 16'(16'h2000 + b), 1'b0, 1'b0, 32'h0, sev_tag(b));
            // R8 clear all flags: condition falls
            op(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 32'h7f, "R8 clear");
          end

    // R6 command write raises the condition in message mode
    do_reset(1'b1, 5'd17);
    op(1'b1, 2'd2, 16'hbeef, 1'b0, 1'b0, 32'h0, "R4 fatal no enable");
    op(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 32'h4, "R6 cmd enable");
    op(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 32'h5, "R6 cmd keep");
    // R2 reserved severity ignored
    op(1'b1, 2'd3, 16'h5555, 1'b0, 1'b0, 32'h0, "R2 sev3");
    // R8 same-cycle clear and correctable message
    op(1'b1, 2'd0, 16'h0a0a, 1'b0, 1'b0, 32'h0, "R2 first cor");
    op(1'b1, 2'd0, 16'h0b0b, 1'b1, 1'b1, 32'h1, "R8 clear+msg");
    // R8 partial clear leaves other bits
    op(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 32'h40, "R8 partial");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule